// File: doc/BRIEF.md
# Two-Source Interrupt Pending Controller

This block decides when a small processor core enters an interrupt routine. It serves two sources. One is internal: a serial receiver's buffer-full flag. The other is an external active-high interrupt pin, which may change at any time relative to the clock.

Each source has its own enable bit. The block latches requests as they arrive and dispatches one of them only on a cycle that the core marks as interruptible. Once a routine is entered, the block raises an acknowledge output. It also raises a vector-select output when the external source is the one in service. Both outputs stay high until the core pulses a return strobe.

A request from the other source that arrives during a routine is held and is served after the return. A fresh assertion of the pin during an external routine is dropped. Such an assertion is taken only if the pin is still high once that routine has ended. Routines never nest.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, `ack_o` and `vsel_o` are low, nothing is pending and both enables are cleared. A pin pulse or a buffer-full rise with no configuration write is never dispatched.
- R2: With the external enable set and the block idle, a pin pulse two clock periods wide is latched. At the next interruptible slot it raises `ack_o` and `vsel_o` on the following edge.
- R3: `ack_o` rises only on the edge that follows a cycle with `slot_i` high. A pending request waits for as long as `slot_i` stays low.
- R4: With the internal enable set, a low-to-high change of `buf_full_i` latches a request. At a slot this request raises `ack_o` with `vsel_o` low.
- R5: `ack_o` (and `vsel_o`, if set) stays high until a cycle with `ret_i` high, and is low after that edge. `ret_i` while idle has no effect.
- R6: A pin pulse that arrives while the internal routine is in service is kept pending. It is dispatched at the first slot after the return.
- R7: A buffer-full rise that arrives while the external routine is in service is kept pending. It is dispatched at the first slot after the return.
- R8: A pin assertion made while the external routine is in service is not latched. If the pin drops before the return, it is never served. If the pin is still high after the return, it is latched and served.
- R9: `buf_rd_i` high clears a pending internal request, so the next slot dispatches nothing.
- R10: `cfg_en_i` is loaded when `cfg_we_i` is high (bit 0 enables the internal source, bit 1 the external source). A source whose bit is 0 is never dispatched.
- R11: When both requests are pending at the same slot, the external source is served first. The internal request stays pending and is served at the first slot after the return.
- R12: While `ack_o` is high, a slot changes neither `ack_o` nor `vsel_o`, so there is no nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous, active high |
| buf_full_i | input | 1 | Serial receive buffer-full flag |
| buf_rd_i | input | 1 | Receive data read strobe; clears the internal request |
| slot_i | input | 1 | Current cycle is interruptible |
| ret_i | input | 1 | Return-from-interrupt strobe |
| cfg_we_i | input | 1 | Load the enable register |
| cfg_en_i | input | 2 | Enable bits: bit 0 internal, bit 1 external |
| ack_o | output | 1 | A routine is in service |
| vsel_o | output | 1 | The routine in service belongs to the external source |

## Verification
The properties assume that the core pulses `ret_i` only to end a routine and raises `slot_i` only as a one-cycle mark. They also assume that `buf_full_i` goes low only together with a `buf_rd_i` read. The directed scenarios drive every strobe for a single cycle, lower the flag only in the same cycle as a read, and always close a routine with one return pulse. Pin pulses are driven on falling clock edges and are at least two periods wide, which is the minimum width the block guarantees to serve.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CFG_W       = 2;
  localparam int CFG_INT_BIT = 0;
  localparam int CFG_EXT_BIT = 1;

  typedef enum logic [1:0] {
    SRV_NONE = 2'd0,
    SRV_INT  = 2'd1,
    SRV_EXT  = 2'd2
  } srv_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[s] <= 1'b0;
          else       chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[s] <= 1'b0;
          else       chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic block_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                  pend_q <= 1'b0;
    else if (clr_i)             pend_q <= 1'b0;
    else if (set_i && !block_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic pend_ext_i,
  input  logic pend_int_i,
  input  logic en_ext_i,
  input  logic en_int_i,
  input  logic slot_i,
  input  logic ret_i,
  output logic disp_ext_o,
  output logic disp_int_o,
  output logic ack_o,
  output logic vsel_o
);
  srv_e srv_q, srv_d;
  logic ack_q, vsel_q;
  logic idle, want_ext, want_int;

  assign idle     = (srv_q == SRV_NONE);
  assign want_ext = pend_ext_i && en_ext_i;
  assign want_int = pend_int_i && en_int_i;

  always_comb begin
    srv_d      = srv_q;
    disp_ext_o = 1'b0;
    disp_int_o = 1'b0;
    if (idle) begin
      if (slot_i && want_ext) begin
        srv_d      = SRV_EXT;
        disp_ext_o = 1'b1;
      end else if (slot_i && want_int) begin
        srv_d      = SRV_INT;
        disp_int_o = 1'b1;
      end
    end else if (ret_i) begin
      srv_d = SRV_NONE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      srv_q  <= SRV_NONE;
      ack_q  <= 1'b0;
      vsel_q <= 1'b0;
    end else begin
      srv_q  <= srv_d;
      ack_q  <= (srv_d != SRV_NONE);
      vsel_q <= (srv_d == SRV_EXT);
    end
  end

  assign ack_o  = ack_q;
  assign vsel_o = vsel_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ext_pin_i,
  input  logic             buf_full_i,
  input  logic             buf_rd_i,
  input  logic             slot_i,
  input  logic             ret_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_en_i,
  output logic             ack_o,
  output logic             vsel_o
);
  logic [CFG_W-1:0] en_q;
  logic             pin_s;
  logic             full_q;
  logic             full_rise;
  logic             pend_ext, pend_int;
  logic             disp_ext, disp_int;
  logic             ext_busy;

  // Enable register
  always_ff @(posedge clk_i) begin
    if (rst_i)         en_q <= '0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  // Pin synchroniser
  irq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (ext_pin_i),
    .q_o   (pin_s)
  );

  // Buffer-full rising edge
  always_ff @(posedge clk_i) begin
    if (rst_i) full_q <= 1'b0;
    else       full_q <= buf_full_i;
  end
  assign full_rise = buf_full_i && !full_q;

  // External routine in service blocks new pin latching
  assign ext_busy = ack_o && vsel_o;

  irq_pend_latch u_ext_pend (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (pin_s && en_q[CFG_EXT_BIT]),
    .block_i (ext_busy),
    .clr_i   (disp_ext),
    .pend_o  (pend_ext)
  );

  irq_pend_latch u_int_pend (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (full_rise && en_q[CFG_INT_BIT]),
    .block_i (1'b0),
    .clr_i   (disp_int || buf_rd_i),
    .pend_o  (pend_int)
  );

  irq_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pend_ext_i (pend_ext),
    .pend_int_i (pend_int),
    .en_ext_i   (en_q[CFG_EXT_BIT]),
    .en_int_i   (en_q[CFG_INT_BIT]),
    .slot_i     (slot_i),
    .ret_i      (ret_i),
    .disp_ext_o (disp_ext),
    .disp_int_o (disp_int),
    .ack_o      (ack_o),
    .vsel_o     (vsel_o)
  );
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       slot_i,
  input logic       ret_i,
  input logic       ack_o,
  input logic       vsel_o,
  input logic [1:0] en_q,
  input logic       pend_ext,
  input logic       pend_int
);
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (!ack_o && !vsel_o)); // R1

  AST_ACK_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ack_o) |-> $past(slot_i)); // R3

  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !ret_i) |=> ack_o); // R5

  AST_RET_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && ret_i) |=> (!ack_o && !vsel_o)); // R5

  AST_VSEL_WITH_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    vsel_o |-> ack_o); // R5

  AST_EXT_HELD_IN_INT: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !vsel_o && pend_ext && !ret_i) |=> pend_ext); // R6

  AST_NO_EXT_LATCH_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && vsel_o) |-> !pend_ext); // R8

  AST_EXT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(ack_o) && vsel_o) |-> $past(en_q[1])); // R10

  AST_INT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(ack_o) && !vsel_o) |-> $past(en_q[0])); // R10

  AST_EXT_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(ack_o) && $past(pend_ext && en_q[1] && pend_int)) |-> vsel_o); // R11

  AST_NO_NEST: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !ret_i) |=> $stable(vsel_o)); // R12
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .slot_i   (slot_i),
  .ret_i    (ret_i),
  .ack_o    (ack_o),
  .vsel_o   (vsel_o),
  .en_q     (en_q),
  .pend_ext (pend_ext),
  .pend_int (pend_int)
);

// File: tb/irq_pend_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       bfull = 1'b0;
  logic       bread = 1'b0;
  logic       slot = 1'b0;
  logic       ret = 1'b0;
  logic       we = 1'b0;
  logic [1:0] en = 2'b00;
  logic       ack, vsel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_pend_ctrl dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .ext_pin_i  (pin),
    .buf_full_i (bfull),
    .buf_rd_i   (bread),
    .slot_i     (slot),
    .ret_i      (ret),
    .cfg_we_i   (we),
    .cfg_en_i   (en),
    .ack_o      (ack),
    .vsel_o     (vsel)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic pulse_slot();  slot = 1'b1; tick(1); slot = 1'b0; endtask
  task automatic pulse_ret();   ret = 1'b1;  tick(1); ret = 1'b0; tick(1); endtask
  task automatic pin_pulse2();  pin = 1'b1;  tick(2); pin = 1'b0; tick(3); endtask
  task automatic full_rise();   bfull = 1'b1; tick(2); endtask
  task automatic read_buf();    bread = 1'b1; bfull = 1'b0; tick(1); bread = 1'b0; tick(1); endtask
  task automatic set_en(input logic [1:0] v); en = v; we = 1'b1; tick(1); we = 1'b0; endtask

  task automatic t_reset();
    tick(1);
    check("R1", "ack/vsel after reset", {ack, vsel}, 2'b00);
    pin_pulse2();
    full_rise();
    pulse_slot();
    check("R1", "no dispatch with enables cleared", {ack, vsel}, 2'b00);
    read_buf();
  endtask

  task automatic t_ext_basic();
    set_en(2'b11);
    pin_pulse2();
    tick(3);
    check("R3", "no dispatch without slot", {ack, vsel}, 2'b00);
    pulse_slot();
    check("R2", "two-cycle pin pulse served", {ack, vsel}, 2'b11);
    tick(4);
    check("R5", "ack held until return", {ack, vsel}, 2'b11);
    ret = 1'b1; tick(1); ret = 1'b0;
    check("R5", "return releases", {ack, vsel}, 2'b00);
    pulse_ret();
    pulse_slot();
    check("R5", "idle return has no effect", {ack, vsel}, 2'b00);
  endtask

  task automatic t_int_then_ext();
    full_rise();
    pulse_slot();
    check("R4", "internal dispatch", {ack, vsel}, 2'b10);
    read_buf();
    pin_pulse2();
    pulse_slot();
    check("R12", "slot during service no nesting", {ack, vsel}, 2'b10);
    pulse_ret();
    check("R6", "after internal return idle", {ack, vsel}, 2'b00);
    pulse_slot();
    check("R6", "held pin request served", {ack, vsel}, 2'b11);
    pulse_ret();
  endtask

  task automatic t_ext_then_int();
    pin_pulse2();
    pulse_slot();
    check("R2", "external dispatch", {ack, vsel}, 2'b11);
    full_rise();
    pulse_slot();
    check("R12", "slot during ext service", {ack, vsel}, 2'b11);
    pulse_ret();
    pulse_slot();
    check("R7", "held buffer-full request served", {ack, vsel}, 2'b10);
    read_buf();
    pulse_ret();
  endtask

  task automatic t_ext_during_ext();
    pin_pulse2();
    pulse_slot();
    check("R2", "external dispatch", {ack, vsel}, 2'b11);
    pin_pulse2();
    pulse_ret();
    tick(3);
    pulse_slot();
    check("R8", "pulse during ext service dropped", {ack, vsel}, 2'b00);
    pin_pulse2();
    pulse_slot();
    check("R8", "ext dispatch again", {ack, vsel}, 2'b11);
    pin = 1'b1;
    tick(3);
    pulse_ret();
    tick(3);
    pulse_slot();
    check("R8", "pin held past return is served", {ack, vsel}, 2'b11);
    pin = 1'b0;
    tick(3);
    pulse_ret();
    tick(2);
    pulse_slot();
    check("R8", "no extra service", {ack, vsel}, 2'b00);
  endtask

  task automatic t_read_clears();
    full_rise();
    read_buf();
    pulse_slot();
    check("R9", "read clears internal request", {ack, vsel}, 2'b00);
  endtask

  task automatic t_disabled();
    set_en(2'b01);
    pin_pulse2();
    pulse_slot();
    check("R10", "external disabled", {ack, vsel}, 2'b00);
    set_en(2'b10);
    full_rise();
    pulse_slot();
    check("R10", "internal disabled", {ack, vsel}, 2'b00);
    read_buf();
    set_en(2'b11);
  endtask

  task automatic t_both();
    full_rise();
    pin_pulse2();
    pulse_slot();
    check("R11", "external wins", {ack, vsel}, 2'b11);
    pulse_ret();
    pulse_slot();
    check("R11", "internal served next", {ack, vsel}, 2'b10);
    read_buf();
    pulse_ret();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_ext_basic();
    t_int_then_ext();
    t_ext_then_int();
    t_ext_during_ext();
    t_read_clears();
    t_disabled();
    t_both();
    tick(4);
    finish_run();
  end
endmodule